// File: doc/BRIEF.md
# Pipelined Burst SRAM Device Model

A synthesizable model of a synchronous, pipelined static RAM that turns the bus around between reads and writes without idle cycles. A small internal array of 36-bit words is split into four 9-bit byte lanes. Each lane carries 8 data bits and 1 parity bit and can be written on its own. Every control and address input is captured on a rising clock edge, but only when the active-low clock enable is asserted. An edge with clock enable high is ignored by every register in the block, including the stages that hold write data and read data.

An access starts on a load cycle: the advance input is low, all three chip selects are in their active state, and the address and direction are captured. While a burst is running, the advance input can be held high to step a 2-bit beat counter. The two low address bits of each beat then follow either an interleaved or a linear order, chosen by a strap input. Read data appears one qualified edge after its address. Write data is taken two qualified edges after its address, which is the slot where a read issued in the same place would have put its data. Because the two slots line up, reads and writes can be mixed on back-to-back cycles.

The data bus is modelled as a separate input word, an output word and an output-drive flag. The data path has a fixed latency and no valid/ready handshake. Back-pressure is expressed only through the clock enable, which stretches the current cycle for the whole pipeline.

Top module: `pbsram_model`

## Requirements
- R1: While reset (`rst_n` low) is applied and on the cycle after it is released, no access is in flight and `dout_en` is 0.
- R2: A load cycle (`adv`=0 with `cen_n`=0) starts an access only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. With any other combination the device is deselected: no array word changes and no read data is driven.
- R3: A read address captured on qualified edge k is presented on `dout`, with `dout_en`=1 when `oe_n`=0, after the next qualified edge k+1.
- R4: A load cycle with `we_n`=0 begins a write. `din` is captured on the second qualified edge after the address edge. Byte lane i (bits 9i+8 down to 9i, so lane 0 is bits 8:0) is written only if `bw_n[i]` was 0 on the address or beat edge. Other lanes keep their old contents.
- R5: While a burst is live, `adv`=1 on a qualified edge steps the beat counter n (0,1,2,3, then wrapping to 0). Beat n uses start[1:0] XOR n when `burst_il`=1 and (start[1:0]+n) mod 4 when `burst_il`=0. Address bits above bit 1 stay fixed.
- R6: A beat keeps the read or write direction of the load cycle that opened its burst, and `we_n` is ignored on advance cycles. The byte-write mask is sampled again on every beat.
- R7: `adv`=1 when no burst is live, after reset or after a deselect, performs no access: nothing is read, nothing is written and no data is driven.
- R8: An edge with `cen_n`=1 changes no state. The captured access, the beat counter, the pending write and `dout` are all held. The device is not deselected: when `cen_n` returns low, the held access completes exactly as if no stall had occurred.
- R9: `dout_en` is 0 during the cycle in which write data is taken, during the first cycle after a deselect and while deselected, whatever `oe_n` is. When read data is present, `dout_en` follows `oe_n` with no clock edge needed.
- R10: A read issued on the cycle right after a write to the same address returns the merged new word. A write issued on the cycle right after a read leaves that read's output intact. Neither case needs an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture on rising edges |
| rst_n | input | 1 | Synchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low; high freezes the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 steps the live burst, 0 loads a new address |
| we_n | input | 1 | Write enable, active low, sampled on load cycles |
| bw_n | input | LANES (4) | Per-lane write mask, active low |
| addr | input | ADDR_W (6) | Word address |
| burst_il | input | 1 | Strap: 1 interleaved order, 0 linear order |
| oe_n | input | 1 | Output enable, active low, applied without a clock |
| din | input | LANES*LANE_W (36) | Write data word |
| dout | output | LANES*LANE_W (36) | Read data word |
| dout_en | output | 1 | 1 when the model would drive the data pins |

## Verification
The bench builds the block with its defaults: ADDR_W=6, LANES=4 and LANE_W=9. With these values the 64-word array is small enough for directed tests to pre-load every word they touch, and each of the four 9-bit lanes can be masked on its own to show which lanes are merged. Bursts start at offsets 1 and 0 within a 4-word block, so interleaved and linear orders give visibly different sequences, and running past four beats exercises the wrap. The same parameters also leave room for the two-edge write delay to overlap a following read of the same word, which exercises the forwarding path.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_ord_e;

  // Low address bits of beat n for a burst opened at offset start.
  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] n,
    input burst_ord_e        ord
  );
    logic [BEAT_W-1:0] sum;
    sum = start + n;
    return (ord == ORD_INTERLEAVED) ? (start ^ n) : sum;
  endfunction

endpackage

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_il,
  output logic              acc_vld,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_ben
);

  logic              sel;
  logic              live_q;
  logic              act_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [LANES-1:0]  ben_q;

  assign sel = !cs1_n && cs2 && !cs3_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      ben_q  <= '0;
    end else if (!cen_n) begin
      if (!adv) begin
        if (sel) begin
          live_q <= 1'b1;
          act_q  <= 1'b1;
          wr_q   <= !we_n;
          base_q <= addr;
          cnt_q  <= '0;
          ben_q  <= ~bw_n;
        end else begin
          live_q <= 1'b0;
          act_q  <= 1'b0;
          wr_q   <= 1'b0;
        end
      end else if (live_q) begin
        act_q <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
        ben_q <= ~bw_n;
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  assign acc_vld  = act_q;
  assign acc_wr   = wr_q;
  assign acc_ben  = ben_q;
  assign acc_addr = {base_q[ADDR_W-1:BEAT_W],
                     beat_offset(base_q[BEAT_W-1:0], cnt_q, burst_ord_e'(burst_il))};

  // R8: a masked edge leaves the captured access untouched
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && cen_n) |=> ($stable(act_q) && $stable(base_q) && $stable(cnt_q) && $stable(wr_q)));

  // R2: a load cycle without a full chip select produces no access
  p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv && !sel) |=> !acc_vld);

  // R7: advancing with no live burst produces no access
  p_noburst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv && !live_q) |=> !acc_vld);

  // R5: a beat only moves the two low address bits
  p_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv && live_q) |=> (acc_vld && acc_addr[ADDR_W-1:BEAT_W] == $past(acc_addr[ADDR_W-1:BEAT_W])));

  // R6: a beat keeps the burst direction
  p_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv && live_q) |=> (acc_wr == $past(acc_wr)));

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    acc_vld,
  input  logic                    acc_wr,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [LANES-1:0]        acc_ben,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];

  logic              wr2_q;
  logic              rd2_q;
  logic [ADDR_W-1:0] addr2_q;
  logic [LANES-1:0]  ben2_q;
  logic [WORD_W-1:0] rd_q;

  logic [WORD_W-1:0] old_word;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic              fwd_hit;

  assign old_word = mem[addr2_q];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_word[l*LANE_W +: LANE_W] =
      ben2_q[l] ? din[l*LANE_W +: LANE_W] : old_word[l*LANE_W +: LANE_W];
  end

  // A read one cycle behind a write to the same word sees the merged data.
  assign fwd_hit = wr2_q && (addr2_q == acc_addr);
  assign rd_word = fwd_hit ? wr_word : mem[acc_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr2_q   <= 1'b0;
      rd2_q   <= 1'b0;
      addr2_q <= '0;
      ben2_q  <= '0;
      rd_q    <= '0;
    end else if (!cen_n) begin
      wr2_q   <= acc_vld && acc_wr;
      rd2_q   <= acc_vld && !acc_wr;
      addr2_q <= acc_addr;
      ben2_q  <= acc_ben;
      if (acc_vld && !acc_wr) rd_q <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cen_n && wr2_q) mem[addr2_q] <= wr_word;
  end

  assign dout    = rd_q;
  assign dout_en = rd2_q && !oe_n;

  // R9: no drive in the cycle after a deselect, idle slot or write address
  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !cen_n && !(acc_vld && !acc_wr)) |=> !dout_en);

  // R8: a masked edge keeps the read output register
  p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && cen_n) |=> ($stable(dout) && $stable(rd2_q)));

endmodule

// File: rtl/pbsram_model.sv
module pbsram_model #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_il,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  logic              acc_vld;
  logic              acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_ben;

  pbsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cen_n    (cen_n),
    .cs1_n    (cs1_n),
    .cs2      (cs2),
    .cs3_n    (cs3_n),
    .adv      (adv),
    .we_n     (we_n),
    .bw_n     (bw_n),
    .addr     (addr),
    .burst_il (burst_il),
    .acc_vld  (acc_vld),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .acc_ben  (acc_ben)
  );

  pbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .cen_n    (cen_n),
    .acc_vld  (acc_vld),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .acc_ben  (acc_ben),
    .din      (din),
    .oe_n     (oe_n),
    .dout     (dout),
    .dout_en  (dout_en)
  );

  // R1: nothing is driven straight out of reset
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !dout_en);

endmodule

// File: tb/pbsram_model_test.sv
module pbsram_model_test;

  localparam int AW = 6;
  localparam int W  = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cen_n;
  logic          cs1_n, cs2, cs3_n;
  logic          adv, we_n;
  logic [3:0]    bw_n;
  logic [AW-1:0] addr;
  logic          burst_il;
  logic          oe_n;
  logic [W-1:0]  din;
  logic [W-1:0]  dout;
  logic          dout_en;

  int  nchk  = 0;
  int  nfail = 0;
  bit  done  = 0;
  logic [W-1:0] v5;

  pbsram_model uut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .burst_il(burst_il), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #4 clk = ~clk;

  function automatic logic [W-1:0] val(input int a);
    logic [7:0] b;
    b = a[7:0];
    return {4'h5, b, 8'hC3, ~b, 8'h3C};
  endfunction

  function automatic logic [W-1:0] mrg(input logic [W-1:0] old, input logic [W-1:0] nw,
                                       input logic [3:0] bwn);
    logic [W-1:0] r;
    r = old;
    for (int l = 0; l < 4; l++) if (!bwn[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input int n, input bit il);
    logic [1:0] nn, lo;
    nn = n[1:0];
    lo = il ? (s[1:0] ^ nn) : 2'(s[1:0] + nn);
    return {s[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic desel(input logic [W-1:0] d);
    cen_n = 0; cs1_n = 1; cs2 = 0; cs3_n = 1; adv = 0; we_n = 1; bw_n = 4'hF; din = d;
    @(negedge clk);
  endtask

  task automatic load(input bit wr, input logic [AW-1:0] a, input logic [3:0] bwn,
                      input logic [W-1:0] d);
    cen_n = 0; cs1_n = 0; cs2 = 1; cs3_n = 0; adv = 0; we_n = !wr; addr = a; bw_n = bwn; din = d;
    @(negedge clk);
  endtask

  task automatic step(input bit wel, input logic [3:0] bwn, input logic [W-1:0] d);
    cen_n = 0; adv = 1; we_n = wel; bw_n = bwn; din = d;
    @(negedge clk);
  endtask

  task automatic stall(input logic [W-1:0] junk);
    cen_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0; adv = 0; we_n = 0; addr = 6'd3; bw_n = 4'h0; din = junk;
    @(negedge clk);
  endtask

  task automatic wr1(input logic [AW-1:0] a, input logic [W-1:0] d, input logic [3:0] bwn);
    load(1, a, bwn, '0);
    desel('0);
    desel(d);
    chk("R9 no drive in write data cycle", W'(dout_en), W'(0));
  endtask

  task automatic rd1(input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
    load(0, a, 4'hF, '0);
    desel('0);
    chk({tag, " read enable"}, W'(dout_en), W'(1));
    chk({tag, " read data"}, dout, exp);
  endtask

  task automatic t_reset();
    rst_n = 0; cen_n = 0; cs1_n = 0; cs2 = 1; cs3_n = 0; adv = 0; we_n = 1;
    bw_n = 4'hF; addr = '0; burst_il = 1; oe_n = 0; din = '0;
    repeat (3) @(negedge clk);
    chk("R1 dout_en in reset", W'(dout_en), W'(0));
    rst_n = 1;
    desel('0);
    chk("R1 dout_en after reset", W'(dout_en), W'(0));
  endtask

  task automatic t_basic();
    wr1(6'd5, val(5), 4'h0);
    rd1(6'd5, val(5), "R3");
    wr1(6'd5, {W{1'b1}}, 4'b1010);
    v5 = mrg(val(5), {W{1'b1}}, 4'b1010);
    rd1(6'd5, v5, "R4 lanes 0 and 2");
  endtask

  task automatic t_select();
    for (int c = 0; c < 3; c++) begin
      cen_n = 0; adv = 0; we_n = 0; addr = 6'd5; bw_n = 4'h0; din = '0;
      cs1_n = (c == 0); cs2 = (c != 1); cs3_n = (c == 2);
      @(negedge clk);
      desel('0);
      chk("R2 no drive after bad select", W'(dout_en), W'(0));
      desel('0);
    end
    rd1(6'd5, v5, "R2 word unchanged");
  endtask

  task automatic t_burst_read(input bit il);
    for (int a = 8; a < 12; a++) wr1(6'(a), val(a), 4'h0);
    burst_il = il;
    load(0, 6'd9, 4'hF, '0);
    for (int j = 1; j <= 6; j++) begin
      step(1, 4'hF, '0);
      chk(il ? "R5 interleaved beat" : "R5 linear beat", dout, val(int'(beat_addr(6'd9, j - 1, il))));
    end
    desel('0);
    burst_il = 1;
  endtask

  task automatic t_burst_write();
    wr1(6'd19, val(19), 4'h0);
    burst_il = 0;
    load(1, 6'd16, 4'h0, '0);
    step(1, 4'h0, '0);
    step(1, 4'h0, val(40));
    chk("R9 no drive during burst write data", W'(dout_en), W'(0));
    step(1, 4'b0111, val(41));
    chk("R9 no drive during burst write data", W'(dout_en), W'(0));
    desel(val(42));
    chk("R6 beat stays a write", W'(dout_en), W'(0));
    desel({W{1'b0}});
    desel('0);
    burst_il = 1;
    rd1(6'd16, val(40), "R6 beat0");
    rd1(6'd17, val(41), "R6 beat1");
    rd1(6'd18, val(42), "R6 beat2");
    rd1(6'd19, mrg(val(19), '0, 4'b0111), "R6 beat3 mask");
  endtask

  task automatic t_noburst();
    desel('0);
    for (int j = 0; j < 3; j++) begin
      addr = 6'd16;
      step(0, 4'h0, {W{1'b1}});
      chk("R7 no access on stray advance", W'(dout_en), W'(0));
    end
    desel({W{1'b1}});
    desel('0);
    rd1(6'd16, val(40), "R7 word unchanged");
  endtask

  task automatic t_cen();
    load(0, 6'd5, 4'hF, '0);
    load(0, 6'd8, 4'hF, '0);
    chk("R8 read before stall", dout, v5);
    for (int j = 0; j < 3; j++) begin
      stall({W{1'b1}});
      chk("R8 dout held", dout, v5);
      chk("R8 drive held", W'(dout_en), W'(1));
    end
    desel('0);
    chk("R8 held read completes", dout, val(8));
    load(1, 6'd10, 4'h0, '0);
    stall({W{1'b1}});
    desel('0);
    stall({W{1'b1}});
    desel(val(50));
    desel('0);
    rd1(6'd10, val(50), "R8 write through stalls");
  endtask

  task automatic t_oe();
    load(0, 6'd8, 4'hF, '0);
    desel('0);
    chk("R9 drive with oe_n low", W'(dout_en), W'(1));
    oe_n = 1; #1;
    chk("R9 oe_n high without clock", W'(dout_en), W'(0));
    oe_n = 0; #1;
    chk("R9 oe_n low without clock", W'(dout_en), W'(1));
    desel('0);
    load(0, 6'd8, 4'hF, '0);
    chk("R9 first cycle out of deselect", W'(dout_en), W'(0));
    desel('0);
  endtask

  task automatic t_turn();
    wr1(6'd20, val(20), 4'h0);
    load(1, 6'd20, 4'b0011, '0);
    load(0, 6'd20, 4'hF, '0);
    desel(val(60));
    chk("R10 read after write forwards", dout, mrg(val(20), val(60), 4'b0011));
    chk("R10 forwarded read drives", W'(dout_en), W'(1));
    load(0, 6'd5, 4'hF, '0);
    load(1, 6'd21, 4'h0, '0);
    chk("R10 read before write intact", dout, v5);
    desel('0);
    desel(val(61));
    desel('0);
    rd1(6'd21, val(61), "R10 write after read");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_select();
    t_burst_read(1);
    t_burst_read(0);
    t_burst_write();
    t_noburst();
    t_cen();
    t_oe();
    t_turn();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule